// File: doc/BRIEF.md
# Receive Interrupt Coalescing Watchdog

This block holds back the receive-complete interrupt of a DMA-driven network receiver so that a burst of frames can be served by a single interrupt. Each time the receive DMA finishes writing a frame to memory it pulses `frm_done`. Alongside the pulse it gives `frm_hold`, the descriptor flag by which that frame asks for its completion interrupt to be deferred. A deferred completion arms a timer. The timer counts system clocks in steps of 256, and the number of steps is taken from an 8-bit count field. When the timer runs out it sets a sticky receive-interrupt status bit and stops. A completion that did not ask for deferral sets the status bit at once and cancels any pending timeout.

Software reaches the block through a small word-wide register port. One word holds the count field and the other holds the status bit, which is cleared by writing 1 to it. The level interrupt `rx_irq` is the status bit gated by `irq_en`.

Top module: `rx_coalesce_wdog`

## Requirements
- R1: After reset the count field reads 0, the status word reads 0 and `rx_irq` is 0.
- R2: Address 0 is the control word, and its bits 7:0 are the read/write count field. Bits 31:8 of that word always read 0, and writes to them are dropped. Address 2 and address 3 read 0 and ignore writes.
- R3: While the count field is 0, a deferred completion starts no timer and the status bit is never set by a timeout.
- R4: A deferred completion (`frm_done`=1, `frm_hold`=1) that arrives while the timer is idle and the count is non-zero starts the timer. The status bit is set at the clock edge that comes exactly count×256 edges after the edge that sampled the completion. After that the timer halts and sets nothing further.
- R5: A deferred completion that arrives while the timer is running does not restart it, so the expiry edge stays where it was.
- R6: A completion with `frm_hold`=0 sets the status bit at the edge that samples it. The same edge returns the timer to idle, so the cancelled run never expires later.
- R7: Writing 0 to the count field while the timer is running stops the timer at that edge without setting the status bit. Writing a non-zero value while it runs leaves the current period unchanged.
- R8: The status bit is bit 6 of the word at address 1. Writing 1 to that bit clears it, and writing 0 to it has no effect. If a set and a clear fall on the same edge, the bit ends up set.
- R9: `rx_irq` is 1 exactly when the status bit is 1 and `irq_en` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address: 0 control, 1 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| frm_done | input | 1 | One-cycle pulse marking that a frame has reached memory |
| frm_hold | input | 1 | Deferral flag of the completed frame's descriptor |
| irq_en | input | 1 | Enable for the interrupt output |
| rx_irq | output | 1 | Level receive interrupt |

## Verification
Directed cases place the expiry on its exact edge for counts 1 and 3 by checking the status one cycle early and then on time. This separates a correct 256-step period from an off-by-one period or a wrong multiplier. Further directed cases send a second deferred frame mid-run, rewrite the count mid-run, send an immediate frame mid-run and write zero mid-run. Together they show whether a running timer is restarted, reloaded, cancelled or stopped, and whether it sets the status bit in each case. A set and a clear on the same edge show which of the two wins. A seeded random phase then mixes completions of both kinds, count writes from 0 to 3, status clears and enable toggles, and compares every cycle against a bench model that keeps the time left as a single cycle count.

// File: rtl/rxc_pkg.sv
package rxc_pkg;
  localparam int unsigned RXC_DATA_W    = 32;
  localparam int unsigned RXC_ADDR_W    = 2;
  localparam logic [1:0]  RXC_ADDR_CTRL = 2'd0;
  localparam logic [1:0]  RXC_ADDR_STAT = 2'd1;
  localparam int unsigned RXC_RI_BIT    = 6;

  // Timeout length in clocks for a given step count and prescaler width.
  function automatic int unsigned rxc_period(input int unsigned steps,
                                             input int unsigned pre_w);
    return steps << pre_w;
  endfunction
endpackage

// File: rtl/rxc_regs.sv
module rxc_regs
  import rxc_pkg::*;
#(
  parameter int unsigned DATA_W = RXC_DATA_W,
  parameter int unsigned ADDR_W = RXC_ADDR_W,
  parameter int unsigned CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              st_i,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              kill_o,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata
);
  logic [CNT_W-1:0] cnt_q;
  logic             ctrl_wr;
  logic             stat_wr;

  assign ctrl_wr = we && (addr == ADDR_W'(RXC_ADDR_CTRL));
  assign stat_wr = we && (addr == ADDR_W'(RXC_ADDR_STAT));
  assign kill_o  = ctrl_wr && (wdata[CNT_W-1:0] == '0);
  assign clr_o   = stat_wr && wdata[RXC_RI_BIT];
  assign cnt_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt_q <= '0;
    else if (ctrl_wr) cnt_q <= wdata[CNT_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(RXC_ADDR_CTRL))      rdata[CNT_W-1:0]  = cnt_q;
    else if (addr == ADDR_W'(RXC_ADDR_STAT)) rdata[RXC_RI_BIT] = st_i;
  end

  // R2
  count_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> (cnt_q == $past(wdata[CNT_W-1:0])));

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(cnt_q));
endmodule

// File: rtl/rxc_timer.sv
module rxc_timer
  import rxc_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             start_req_i,
  input  logic             cancel_i,
  input  logic             kill_i,
  output logic             expire_o,
  output logic             running_o
);
  localparam int unsigned AGE_W = CNT_W + PRE_W;

  logic             run_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] down_q;
  logic             pre_last;
  logic             start;

  assign pre_last  = &pre_q;
  assign expire_o  = run_q && pre_last && (down_q == '0) && !kill_i && !cancel_i;
  assign start     = !run_q && start_req_i && (cnt_i != '0) && !kill_i && !cancel_i;
  assign running_o = run_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      down_q <= '0;
    end else if (cancel_i || kill_i || expire_o) begin
      run_q  <= 1'b0;
      pre_q  <= '0;
      down_q <= '0;
    end else if (run_q) begin
      pre_q <= pre_q + 1'b1;
      if (pre_last) down_q <= down_q - 1'b1;
    end else if (start) begin
      run_q  <= 1'b1;
      pre_q  <= '0;
      down_q <= cnt_i - 1'b1;
    end
  end

  // Checker-side run age: counts edges since the start of the run.
  logic [AGE_W-1:0] age_q;
  logic [CNT_W-1:0] load_q;
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      age_q  <= '0;
      load_q <= '0;
    end else if (start) begin
      age_q  <= '0;
      load_q <= cnt_i;
    end else if (run_q) begin
      age_q  <= age_q + 1'b1;
    end
  end

  // R3
  run_needs_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_i != '0));

  // R4
  expire_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (32'(age_q) + 32'd1 == rxc_period(32'(load_q), PRE_W)));

  // R4
  expire_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !run_q);

  // R5
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !cancel_i && !kill_i && !expire_o) |=> (pre_q == $past(pre_q) + 1'b1));

  // R6
  cancel_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cancel_i |=> !run_q);

  // R7
  kill_idles_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kill_i |=> !run_q);
endmodule

// File: rtl/rxc_status.sv
module rxc_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic irq_en_i,
  output logic st_o,
  output logic irq_o
);
  logic st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= 1'b0;
    else        st_q <= set_i || (st_q && !clr_i);
  end

  assign st_o  = st_q;
  assign irq_o = st_q && irq_en_i;

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> st_q);

  // R8
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !st_q);

  // R8
  sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !clr_i) |=> $stable(st_q));
endmodule

// File: rtl/rx_coalesce_wdog.sv
module rx_coalesce_wdog
  import rxc_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned PRE_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_we,
  input  logic [RXC_ADDR_W-1:0] reg_addr,
  input  logic [RXC_DATA_W-1:0] reg_wdata,
  output logic [RXC_DATA_W-1:0] reg_rdata,
  input  logic                  frm_done,
  input  logic                  frm_hold,
  input  logic                  irq_en,
  output logic                  rx_irq
);
  logic [CNT_W-1:0] cnt;
  logic             cnt_kill;
  logic             st_clr;
  logic             st;
  logic             frm_defer;
  logic             frm_cancel;
  logic             tmr_expire;
  logic             tmr_running;
  logic             st_set;

  assign frm_defer  = frm_done && frm_hold;
  assign frm_cancel = frm_done && !frm_hold;
  assign st_set     = tmr_expire || frm_cancel;

  rxc_regs #(.DATA_W(RXC_DATA_W), .ADDR_W(RXC_ADDR_W), .CNT_W(CNT_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .st_i(st), .cnt_o(cnt), .kill_o(cnt_kill), .clr_o(st_clr), .rdata(reg_rdata)
  );

  rxc_timer #(.CNT_W(CNT_W), .PRE_W(PRE_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .start_req_i(frm_defer),
    .cancel_i(frm_cancel), .kill_i(cnt_kill), .expire_o(tmr_expire),
    .running_o(tmr_running)
  );

  rxc_status status_i (
    .clk(clk), .rst_n(rst_n), .set_i(st_set), .clr_i(st_clr),
    .irq_en_i(irq_en), .st_o(st), .irq_o(rx_irq)
  );

  // R7
  kill_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_running && cnt_kill && !frm_cancel && !st && !st_clr) |=> !st);

  // R6
  cancel_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frm_cancel |=> (st && !tmr_running));
endmodule

// File: tb/rx_coalesce_wdog_tb_top.sv
module rx_coalesce_wdog_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        frm_done = 1'b0;
  logic        frm_hold = 1'b0;
  logic        irq_en = 1'b0;
  logic        rx_irq;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rx_coalesce_wdog dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .frm_done(frm_done),
    .frm_hold(frm_hold), .irq_en(irq_en), .rx_irq(rx_irq)
  );

  // Bench model: time left is one plain cycle count.
  function automatic int unsigned ticks_for(input int unsigned c);
    return c * 256;
  endfunction

  logic [7:0]  m_cnt;
  logic        m_run;
  int unsigned m_left;
  logic        m_st;

  always @(posedge clk) begin
    logic kill, cancel, fire, clr;
    if (!rst_n) begin
      m_cnt <= '0; m_run <= 1'b0; m_left <= 0; m_st <= 1'b0;
    end else begin
      kill   = reg_we && reg_addr == 2'd0 && reg_wdata[7:0] == 8'd0;
      cancel = frm_done && !frm_hold;
      fire   = m_run && m_left == 1 && !kill && !cancel;
      clr    = reg_we && reg_addr == 2'd1 && reg_wdata[6];
      m_st  <= fire || cancel || (m_st && !clr);
      if (reg_we && reg_addr == 2'd0) m_cnt <= reg_wdata[7:0];
      if (cancel || kill || fire) m_run <= 1'b0;
      else if (m_run) m_left <= m_left - 1;
      else if (frm_done && frm_hold && m_cnt != 0) begin
        m_run <= 1'b1; m_left <= ticks_for(m_cnt);
      end
    end
  end

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    if (a == 2'd0) return {24'd0, m_cnt};
    if (a == 2'd1) return {25'd0, m_st, 6'd0};
    return 32'd0;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_check();
    chk("R1-model rdata", reg_rdata, exp_rd(reg_addr));
    chk("R9 model irq", {31'd0, rx_irq}, {31'd0, m_st & irq_en});
  endtask

  task automatic drive(input logic we, input logic [1:0] a, input logic [31:0] wd,
                       input logic d, input logic h);
    @(negedge clk);
    if (rst_n) model_check();
    reg_we = we; reg_addr = a; reg_wdata = wd; frm_done = d; frm_hold = h;
  endtask

  task automatic nop(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 2'd1, 32'd0, 1'b0, 1'b0);
  endtask

  task automatic expect_rd(input string tag, input logic [1:0] a, input logic [31:0] exp);
    drive(1'b0, a, 32'd0, 1'b0, 1'b0);
    #1 chk(tag, reg_rdata, exp);
  endtask

  task automatic clear_st();
    drive(1'b1, 2'd1, 32'h0000_0040, 1'b0, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    expect_rd("R1 count", 2'd0, 32'd0);
    expect_rd("R1 status", 2'd1, 32'd0);
    chk("R1 irq", {31'd0, rx_irq}, 32'd0);

    // R2 field width, reserved bits, unused addresses
    drive(1'b1, 2'd0, 32'hFFFF_FFA5, 1'b0, 1'b0);
    expect_rd("R2 count rw", 2'd0, 32'h0000_00A5);
    drive(1'b1, 2'd2, 32'hFFFF_FFFF, 1'b0, 1'b0);
    expect_rd("R2 addr2 zero", 2'd2, 32'd0);
    expect_rd("R2 count kept", 2'd0, 32'h0000_00A5);

    // R3 zero count never runs
    drive(1'b1, 2'd0, 32'd0, 1'b0, 1'b0);
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b1);
    nop(300);
    expect_rd("R3 no expiry", 2'd1, 32'd0);

    // R4 count 1: expiry exactly 256 edges after the start edge
    drive(1'b1, 2'd0, 32'd1, 1'b0, 1'b0);
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b1);
    nop(255);
    expect_rd("R4 one early", 2'd1, 32'd0);
    expect_rd("R4 on time", 2'd1, 32'h40);
    clear_st();
    expect_rd("R8 w1c", 2'd1, 32'd0);
    nop(600);
    expect_rd("R4 halted", 2'd1, 32'd0);

    // R5 second deferred frame does not restart
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b1);
    nop(100);
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b1);
    nop(154);
    expect_rd("R5 one early", 2'd1, 32'd0);
    expect_rd("R5 on time", 2'd1, 32'h40);
    clear_st();

    // R7 non-zero rewrite mid-run keeps period
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b1);
    nop(50);
    drive(1'b1, 2'd0, 32'd3, 1'b0, 1'b0);
    nop(204);
    expect_rd("R7 rewrite early", 2'd1, 32'd0);
    expect_rd("R7 rewrite on time", 2'd1, 32'h40);
    clear_st();

    // R4 count 3: 768 edges
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b1);
    nop(767);
    expect_rd("R4 c3 one early", 2'd1, 32'd0);
    expect_rd("R4 c3 on time", 2'd1, 32'h40);
    clear_st();

    // R6 immediate frame sets now and cancels the run
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b1);
    nop(10);
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b0);
    expect_rd("R6 immediate set", 2'd1, 32'h40);
    clear_st();
    nop(800);
    expect_rd("R6 no late expiry", 2'd1, 32'd0);

    // R7 zero write stops the run silently
    drive(1'b0, 2'd1, 32'd0, 1'b1, 1'b1);
    nop(10);
    drive(1'b1, 2'd0, 32'd0, 1'b0, 1'b0);
    nop(800);
    expect_rd("R7 kill no set", 2'd1, 32'd0);
    expect_rd("R7 count zero", 2'd0, 32'd0);

    // R8 set wins over clear, writing 0 has no effect
    drive(1'b1, 2'd1, 32'h0000_0040, 1'b1, 1'b0);
    expect_rd("R8 set wins", 2'd1, 32'h40);
    drive(1'b1, 2'd1, 32'hFFFF_FFBF, 1'b0, 1'b0);
    expect_rd("R8 write0 no effect", 2'd1, 32'h40);

    // R9 interrupt gating
    irq_en = 1'b0;
    #1 chk("R9 gated off", {31'd0, rx_irq}, 32'd0);
    irq_en = 1'b1;
    #1 chk("R9 gated on", {31'd0, rx_irq}, 32'd1);
    clear_st();
    expect_rd("R8 cleared", 2'd1, 32'd0);
    #1 chk("R9 follows status", {31'd0, rx_irq}, 32'd0);

    // Random phase against the bench model
    for (int i = 0; i < 6000; i++) begin
      logic we, d, h;
      logic [1:0] a;
      logic [31:0] wd;
      we = 1'b0; a = 2'($urandom_range(0, 3)); wd = $urandom; d = 1'b0; h = 1'b0;
      if ($urandom_range(0, 39) == 0) begin d = 1'b1; h = ($urandom_range(0, 3) != 0); end
      if ($urandom_range(0, 199) == 0) begin
        we = 1'b1; a = 2'd0; wd = {$urandom, 2'($urandom_range(0, 3))} ;
        wd[7:0] = 8'($urandom_range(0, 3));
      end else if ($urandom_range(0, 29) == 0) begin
        we = 1'b1; a = 2'd1;
      end
      if ($urandom_range(0, 99) == 0) irq_en = ~irq_en;
      drive(we, a, wd, d, h);
    end
    nop(2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule